// File: doc/BRIEF.md
# Optical Pickup Track Jump Sequencer

This block turns decoded host commands into drive pulses for the tracking actuator of an optical pickup. A jump command starts an acceleration kick on one of the two actuator outputs, follows it with a deceleration kick of the opposite polarity, and ends with a timed brake. A phase ends either after a number of time ticks or after a number of track crossings reported by the tracking-error comparator. The command's direction bit chooses which output takes the acceleration kick. The block also offers a long track check with no kicks, a brake-only command, and a two-byte counting mode. In counting mode the tracking loop is held open while the block counts crossings, and it raises a progress flag at the half-way point of each round.

The host presents one byte per `cmd_we` pulse. A counting sequence is sent inside a window where `cmd_stb` is held high: the count command byte first, then the count byte. Counting starts when `cmd_stb` falls. All durations are counted in pulses of `tick`, a one-cycle enable divided down from the crystal clock. With the default parameters and a 1 µs tick, the kick is 233 ticks, the long deceleration kick is 466 ticks and the brake is 24 000 ticks.

Top module: `track_jump_seq`

## Requirements
- R1: After reset all outputs are low and the block is idle. Crossing qualification is off, so every rising edge of `te_cmp` counts as a crossing.
- R2: Command byte layout is bits [7:5] kind, bit 4 direction (0 = inward, 1 = outward), bit 3 reserved and required to be 0, bits [2:0] length. Kind 3'b001 with length 0 is a one-track jump: KICK_TICKS ticks of acceleration on `kick_pos` (inward) or `kick_neg` (outward), then KICK_TICKS ticks of deceleration on the other output, then BRAKE_TICKS ticks of brake.
- R3: Length 1 is a four-track jump. Acceleration lasts until the 2nd crossing, and deceleration lasts DEC4_TICKS ticks.
- R4: Lengths 2, 3, 4 and 5 accelerate for 9·2^(len−2) crossings and decelerate for 7·2^(len−2) crossings (9/7, 18/14, 36/28, 72/56).
- R5: While a kick is active, `trk_off` and `servo_hold` are high. During the brake, `gain_up` is high, both kicks and `servo_hold` are low, and `trk_off` equals `te_cmp` XOR the direction bit.
- R6: Kind 3'b010 is a track check. It produces no kicks and holds `trk_off` high until CHECK_TRACKS crossings have been seen, then runs the brake.
- R7: Kind 3'b011 runs the brake alone.
- R8: When the brake ends, the block returns to idle by itself with all outputs low, and it stays idle.
- R9: A valid jump command replaces a running sequence in the next cycle. Bytes with an unknown kind, with length 6 or 7, or with bit 3 set change nothing.
- R10: Kind 3'b100 arms a count. The next byte is the count N, where 0 stands for 256. Counting starts only when `cmd_stb` falls, and `trk_off` stays high while counting.
- R11: While counting, `half_flag` is high when (crossings mod N) ≥ floor(N/2). At N crossings the count wraps and starts again. Byte 8'hFF stops it and returns the block to idle.
- R12: Kind 3'b101 sets qualification from bit 0. When qualification is 1, a rising edge of `te_cmp` counts as a crossing only if `rf_ok` is high.
- R13: Timed phases advance only on cycles where `tick` is high. With `tick` held low, a timed phase does not end.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Time-base enable pulse |
| cmd_stb | input | 1 | Command window; its falling edge starts a count |
| cmd_we | input | 1 | Command byte valid |
| cmd_byte | input | 8 | Decoded command or count byte |
| te_cmp | input | 1 | Tracking-error comparator |
| rf_ok | input | 1 | RF-present comparator |
| kick_pos | output | 1 | Positive actuator kick |
| kick_neg | output | 1 | Negative actuator kick |
| trk_off | output | 1 | Tracking loop open |
| gain_up | output | 1 | Tracking gain boost (brake) |
| servo_hold | output | 1 | Tracking servo hold during kicks |
| half_flag | output | 1 | Count progress flag |

## Verification
Jumps of every length are run in both directions. For the timed splits, no crossings are supplied, so the measured kick widths show the tick-based limits on their own. For the track-based splits, a regular crossing train is supplied and the crossings seen in each phase are counted; this separates each length's split and catches a swapped order or wrong polarity. Count runs use an even N, an odd N and a qualified mode in which every other edge arrives without `rf_ok`; this shows the half-point, the wrap and the qualification rule. Preemption, ignored bytes and a frozen tick are each applied in the middle of a sequence, and the kick widths that follow are measured to show their effect.

// File: rtl/trkjmp_pkg.sv
package trkjmp_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ACC,
        ST_DEC,
        ST_BRK,
        ST_CHK,
        ST_CNT
    } phase_e;

    // How each phase of a jump ends: by time or by crossings
    typedef struct packed {
        logic       a_time;
        logic       b_time;
        logic       b_long;
        logic [7:0] a_trk;
        logic [7:0] b_trk;
    } jump_plan_t;

    localparam logic [2:0] K_JUMP  = 3'b001;
    localparam logic [2:0] K_CHECK = 3'b010;
    localparam logic [2:0] K_BRAKE = 3'b011;
    localparam logic [2:0] K_COUNT = 3'b100;
    localparam logic [2:0] K_MODE  = 3'b101;
    localparam logic [7:0] STOP_BYTE = 8'hFF;

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    function automatic logic len_ok(input logic [2:0] len);
        return len <= 3'd5;
    endfunction

    function automatic jump_plan_t plan_for(input logic [2:0] len);
        jump_plan_t p;
        p = '0;
        case (len)
            3'd0: begin
                p.a_time = 1'b1;
                p.b_time = 1'b1;
            end
            3'd1: begin
                p.a_trk  = 8'd2;
                p.b_time = 1'b1;
                p.b_long = 1'b1;
            end
            default: begin
                p.a_trk = 8'd9 << (len - 3'd2);
                p.b_trk = 8'd7 << (len - 3'd2);
            end
        endcase
        return p;
    endfunction

endpackage

// File: rtl/trkjmp_cross_det.sv
module trkjmp_cross_det (
    input  logic clk,
    input  logic rst,
    input  logic te_cmp,
    input  logic rf_ok,
    input  logic qualify,
    output logic xing
);
    logic te_q;

    always_ff @(posedge clk) begin
        if (rst) te_q <= 1'b0;
        else     te_q <= te_cmp;
    end

    assign xing = te_cmp & ~te_q & (~qualify | rf_ok);

    // R12: one rising edge yields a single crossing
    assert_xing_single_R12: assert property (@(posedge clk) disable iff (rst)
        xing |=> !xing);

endmodule

// File: rtl/trkjmp_cmd_dec.sv
module trkjmp_cmd_dec
    import trkjmp_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       cmd_stb,
    input  logic       cmd_we,
    input  logic [7:0] cmd_byte,
    output logic       go_jump,
    output logic       go_check,
    output logic       go_brake,
    output logic       go_count,
    output logic       go_reset,
    output logic       cmd_dir,
    output logic [2:0] cmd_len,
    output logic [8:0] count_n,
    output logic       qualify
);
    logic       stb_q, await_n, have_n, qual_q;
    logic [8:0] n_reg;
    logic [2:0] kind;
    logic       fmt_ok, plain, stb_fall;

    assign kind     = cmd_byte[7:5];
    assign cmd_dir  = cmd_byte[4];
    assign cmd_len  = cmd_byte[2:0];
    assign fmt_ok   = ~cmd_byte[3];
    assign plain    = cmd_we & ~await_n;
    assign stb_fall = stb_q & ~cmd_stb;

    assign go_reset = plain & (cmd_byte == STOP_BYTE);
    assign go_jump  = plain & fmt_ok & (kind == K_JUMP) & len_ok(cmd_len);
    assign go_check = plain & fmt_ok & (kind == K_CHECK);
    assign go_brake = plain & fmt_ok & (kind == K_BRAKE);
    assign go_count = stb_fall & have_n;
    assign count_n  = n_reg;
    assign qualify  = qual_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            stb_q   <= 1'b0;
            await_n <= 1'b0;
            have_n  <= 1'b0;
            qual_q  <= 1'b0;
            n_reg   <= '0;
        end else begin
            stb_q <= cmd_stb;
            if (cmd_we && await_n) begin
                n_reg   <= (cmd_byte == 8'd0) ? 9'd256 : {1'b0, cmd_byte};
                await_n <= 1'b0;
                have_n  <= 1'b1;
            end else if (plain && fmt_ok && kind == K_COUNT) begin
                await_n <= 1'b1;
                have_n  <= 1'b0;
            end else if (go_reset) begin
                await_n <= 1'b0;
                have_n  <= 1'b0;
            end
            if (plain && fmt_ok && kind == K_MODE)
                qual_q <= cmd_byte[0];
            if (stb_fall) begin
                await_n <= 1'b0;
                have_n  <= 1'b0;
            end
        end
    end

    // R10: a count starts only on the strobe's falling edge
    assert_count_on_fall_R10: assert property (@(posedge clk) disable iff (rst)
        go_count |-> ($past(cmd_stb) && !cmd_stb));

endmodule

// File: rtl/trkjmp_phase_ctl.sv
module trkjmp_phase_ctl
    import trkjmp_pkg::*;
#(
    parameter int KICK_TICKS   = 233,
    parameter int DEC4_TICKS   = 466,
    parameter int BRAKE_TICKS  = 24000,
    parameter int CHECK_TRACKS = 256
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick,
    input  logic       xing,
    input  logic       te_raw,
    input  logic       go_jump,
    input  logic       go_check,
    input  logic       go_brake,
    input  logic       go_count,
    input  logic       go_reset,
    input  logic       cmd_dir,
    input  jump_plan_t cmd_plan,
    input  logic [8:0] count_n,
    output logic       kick_pos,
    output logic       kick_neg,
    output logic       trk_off,
    output logic       gain_up,
    output logic       servo_hold,
    output logic       half_flag
);
    localparam int MAXL = imax(imax(KICK_TICKS, DEC4_TICKS),
                               imax(BRAKE_TICKS, imax(CHECK_TRACKS, 256)));
    localparam int CW   = $clog2(MAXL + 1);

    phase_e          state;
    jump_plan_t      plan_q;
    logic            dir_q;
    logic [8:0]      n_q;
    logic [CW-1:0]   cnt, lim;
    logic            step, last, any_go;
    logic            in_acc, in_dec, in_brk;

    assign any_go = go_jump | go_check | go_brake | go_count | go_reset;

    always_comb begin
        step = 1'b0;
        lim  = CW'(1);
        case (state)
            ST_ACC: begin
                step = plan_q.a_time ? tick : xing;
                lim  = plan_q.a_time ? CW'(KICK_TICKS) : CW'(plan_q.a_trk);
            end
            ST_DEC: begin
                step = plan_q.b_time ? tick : xing;
                lim  = !plan_q.b_time ? CW'(plan_q.b_trk) :
                       plan_q.b_long  ? CW'(DEC4_TICKS) : CW'(KICK_TICKS);
            end
            ST_BRK: begin
                step = tick;
                lim  = CW'(BRAKE_TICKS);
            end
            ST_CHK: begin
                step = xing;
                lim  = CW'(CHECK_TRACKS);
            end
            ST_CNT: begin
                step = xing;
                lim  = CW'(n_q);
            end
            default: ;
        endcase
    end

    assign last = step && (cnt == lim - CW'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            cnt    <= '0;
            dir_q  <= 1'b0;
            plan_q <= '0;
            n_q    <= '0;
        end else if (go_reset) begin
            state <= ST_IDLE;
            cnt   <= '0;
        end else if (go_jump) begin
            state  <= ST_ACC;
            cnt    <= '0;
            dir_q  <= cmd_dir;
            plan_q <= cmd_plan;
        end else if (go_check) begin
            state <= ST_CHK;
            cnt   <= '0;
            dir_q <= cmd_dir;
        end else if (go_brake) begin
            state <= ST_BRK;
            cnt   <= '0;
            dir_q <= cmd_dir;
        end else if (go_count) begin
            state <= ST_CNT;
            cnt   <= '0;
            n_q   <= count_n;
        end else if (step) begin
            if (last) begin
                cnt <= '0;
                case (state)
                    ST_ACC:  state <= ST_DEC;
                    ST_DEC:  state <= ST_BRK;
                    ST_CHK:  state <= ST_BRK;
                    ST_CNT:  state <= ST_CNT;
                    default: state <= ST_IDLE;
                endcase
            end else begin
                cnt <= cnt + CW'(1);
            end
        end
    end

    assign in_acc     = (state == ST_ACC);
    assign in_dec     = (state == ST_DEC);
    assign in_brk     = (state == ST_BRK);
    assign kick_pos   = (in_acc & ~dir_q) | (in_dec & dir_q);
    assign kick_neg   = (in_acc & dir_q) | (in_dec & ~dir_q);
    assign servo_hold = in_acc | in_dec;
    assign gain_up    = in_brk;
    assign trk_off    = in_acc | in_dec | (state == ST_CHK) | (state == ST_CNT)
                      | (in_brk & (te_raw ^ dir_q));
    assign half_flag  = (state == ST_CNT) && (cnt >= CW'(n_q >> 1));

    // R2: acceleration is followed only by deceleration
    assert_acc_then_dec_R2: assert property (@(posedge clk) disable iff (rst)
        (in_acc && !any_go) |=> (state == ST_ACC || state == ST_DEC));

    // R8: the brake ends in idle
    assert_brake_exit_R8: assert property (@(posedge clk) disable iff (rst)
        (in_brk && !any_go) |=> (state == ST_BRK || state == ST_IDLE));

    // R9: a valid jump takes over in the next cycle
    assert_preempt_R9: assert property (@(posedge clk) disable iff (rst)
        go_jump |=> (state == ST_ACC && cnt == '0));

    // R11: the count stays inside one round and the stop byte clears it
    assert_cnt_bound_R11: assert property (@(posedge clk) disable iff (rst)
        (state == ST_CNT) |-> (cnt < CW'(n_q)));
    assert_stop_idle_R11: assert property (@(posedge clk) disable iff (rst)
        go_reset |=> (state == ST_IDLE && !half_flag && !trk_off));

    // R13: no tick, no progress in the brake
    assert_tick_freeze_R13: assert property (@(posedge clk) disable iff (rst)
        (in_brk && !tick && !any_go) |=> $stable(cnt));

endmodule

// File: rtl/track_jump_seq.sv
module track_jump_seq
    import trkjmp_pkg::*;
#(
    parameter int KICK_TICKS   = 233,
    parameter int DEC4_TICKS   = 466,
    parameter int BRAKE_TICKS  = 24000,
    parameter int CHECK_TRACKS = 256
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick,
    input  logic       cmd_stb,
    input  logic       cmd_we,
    input  logic [7:0] cmd_byte,
    input  logic       te_cmp,
    input  logic       rf_ok,
    output logic       kick_pos,
    output logic       kick_neg,
    output logic       trk_off,
    output logic       gain_up,
    output logic       servo_hold,
    output logic       half_flag
);
    logic       go_jump, go_check, go_brake, go_count, go_reset;
    logic       cmd_dir, qualify, xing;
    logic [2:0] cmd_len;
    logic [8:0] count_n;

    trkjmp_cmd_dec u_dec (
        .clk      (clk),
        .rst      (rst),
        .cmd_stb  (cmd_stb),
        .cmd_we   (cmd_we),
        .cmd_byte (cmd_byte),
        .go_jump  (go_jump),
        .go_check (go_check),
        .go_brake (go_brake),
        .go_count (go_count),
        .go_reset (go_reset),
        .cmd_dir  (cmd_dir),
        .cmd_len  (cmd_len),
        .count_n  (count_n),
        .qualify  (qualify)
    );

    trkjmp_cross_det u_xing (
        .clk     (clk),
        .rst     (rst),
        .te_cmp  (te_cmp),
        .rf_ok   (rf_ok),
        .qualify (qualify),
        .xing    (xing)
    );

    trkjmp_phase_ctl #(
        .KICK_TICKS   (KICK_TICKS),
        .DEC4_TICKS   (DEC4_TICKS),
        .BRAKE_TICKS  (BRAKE_TICKS),
        .CHECK_TRACKS (CHECK_TRACKS)
    ) u_phase (
        .clk        (clk),
        .rst        (rst),
        .tick       (tick),
        .xing       (xing),
        .te_raw     (te_cmp),
        .go_jump    (go_jump),
        .go_check   (go_check),
        .go_brake   (go_brake),
        .go_count   (go_count),
        .go_reset   (go_reset),
        .cmd_dir    (cmd_dir),
        .cmd_plan   (plan_for(cmd_len)),
        .count_n    (count_n),
        .kick_pos   (kick_pos),
        .kick_neg   (kick_neg),
        .trk_off    (trk_off),
        .gain_up    (gain_up),
        .servo_hold (servo_hold),
        .half_flag  (half_flag)
    );

endmodule

// File: tb/tb_track_jump_seq.sv
module tb_track_jump_seq;

    localparam int KICK  = 3;
    localparam int DEC4  = 5;
    localparam int BRAKE = 12;
    localparam int CHECK = 256;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick = 1'b1;
    logic       cmd_stb = 1'b0;
    logic       cmd_we = 1'b0;
    logic [7:0] cmd_byte = 8'h00;
    logic       te_cmp = 1'b0;
    logic       rf_ok = 1'b1;
    logic       kick_pos, kick_neg, trk_off, gain_up, servo_hold, half_flag;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    track_jump_seq #(
        .KICK_TICKS   (KICK),
        .DEC4_TICKS   (DEC4),
        .BRAKE_TICKS  (BRAKE),
        .CHECK_TRACKS (CHECK)
    ) dut (
        .clk        (clk),
        .rst        (rst),
        .tick       (tick),
        .cmd_stb    (cmd_stb),
        .cmd_we     (cmd_we),
        .cmd_byte   (cmd_byte),
        .te_cmp     (te_cmp),
        .rf_ok      (rf_ok),
        .kick_pos   (kick_pos),
        .kick_neg   (kick_neg),
        .trk_off    (trk_off),
        .gain_up    (gain_up),
        .servo_hold (servo_hold),
        .half_flag  (half_flag)
    );

    task automatic expect_eq(input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: got %0d expected %0d", what, act, exp);
        end
    endtask

    function automatic int quiet();
        return (kick_pos | kick_neg | trk_off | gain_up | servo_hold | half_flag) ? 0 : 1;
    endfunction

    task automatic send(input logic [7:0] b);
        @(negedge clk);
        cmd_we   = 1'b1;
        cmd_byte = b;
        @(negedge clk);
        cmd_we   = 1'b0;
    endtask

    // Samples one sequence from the current negedge until the block is idle
    task automatic run_seq(input bit dirv, input bit gen,
                           output int a_c, output int b_c, output int br_c,
                           output int a_x, output int b_x, output int c_x,
                           output int bad);
        int i = 0;
        int last_rank = 0;
        bit done = 1'b0;
        a_c = 0; b_c = 0; br_c = 0; a_x = 0; b_x = 0; c_x = 0; bad = 0;
        while (!done && i < 5000) begin
            logic acc, dec;
            int rank;
            acc = dirv ? kick_neg : kick_pos;
            dec = dirv ? kick_pos : kick_neg;
            if (quiet() == 1) begin
                done = 1'b1;
            end else begin
                rank = acc ? 1 : dec ? 2 : gain_up ? 3 : 2;
                if (rank < last_rank) bad++;
                last_rank = rank;
                if (acc || dec) begin
                    if (!(trk_off && servo_hold) || (kick_pos && kick_neg)) bad++;
                end else if (gain_up) begin
                    if (trk_off != (te_cmp ^ dirv) || servo_hold) bad++;
                end else if (servo_hold || !trk_off) begin
                    bad++;
                end
                if (acc) a_c++;
                else if (dec) b_c++;
                else if (gain_up) br_c++;
                te_cmp = gen && (i % 4 == 0);
                if (te_cmp) begin
                    if (acc) a_x++;
                    else if (dec) b_x++;
                    else if (!gain_up) c_x++;
                end
                i++;
                @(negedge clk);
            end
        end
        te_cmp = 1'b0;
        if (!done) bad += 1000;
    endtask

    task automatic count_run(input int n_byte, input bit qual);
        int nv = (n_byte == 0) ? 256 : n_byte;
        int k = 0;
        send(qual ? 8'hA1 : 8'hA0);
        @(negedge clk);
        cmd_stb = 1'b1;
        send(8'h80);
        send(n_byte[7:0]);
        repeat (2) @(negedge clk);
        expect_eq("R10 count waits for strobe fall (trk_off)", trk_off, 0);
        cmd_stb = 1'b0;
        @(negedge clk);
        expect_eq("R10 trk_off high once counting", trk_off, 1);
        expect_eq("R11 flag low at count start", half_flag, 0);
        for (int j = 0; j < 2 * nv + 3; j++) begin
            rf_ok  = qual ? (j % 2 == 0) : 1'b1;
            te_cmp = 1'b1;
            if (rf_ok || !qual) k++;
            @(negedge clk);
            te_cmp = 1'b0;
            rf_ok  = 1'b1;
            expect_eq(qual ? "R12 qualified half flag" : "R11 half flag",
                      half_flag, ((k % nv) >= nv / 2) ? 1 : 0);
            expect_eq("R10 trk_off while counting", trk_off, 1);
            repeat (2) @(negedge clk);
        end
        send(8'hFF);
        expect_eq("R11 stop byte clears trk_off", trk_off, 0);
        expect_eq("R11 stop byte clears flag", half_flag, 0);
        send(8'hA0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL R8 watchdog: got %0d expected %0d", 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int a_c, b_c, br_c, a_x, b_x, c_x, bad;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        expect_eq("R1 outputs quiet after reset", quiet(), 1);

        // R2: one-track jumps, both directions, no crossings supplied
        for (int d = 0; d < 2; d++) begin
            send(d ? 8'h30 : 8'h20);
            run_seq(d[0], 1'b0, a_c, b_c, br_c, a_x, b_x, c_x, bad);
            expect_eq("R2 accel ticks", a_c, KICK);
            expect_eq("R2 decel ticks", b_c, KICK);
            expect_eq("R2 brake ticks", br_c, BRAKE);
            expect_eq("R5 phase outputs", bad, 0);
            repeat (5) @(negedge clk);
            expect_eq("R8 idle after one-track", quiet(), 1);
        end

        // R3: four-track jump
        for (int d = 0; d < 2; d++) begin
            send(d ? 8'h31 : 8'h21);
            run_seq(d[0], 1'b1, a_c, b_c, br_c, a_x, b_x, c_x, bad);
            expect_eq("R3 accel crossings", a_x, 2);
            expect_eq("R3 decel ticks", b_c, DEC4);
            expect_eq("R5 brake ticks with slip", br_c, BRAKE);
            expect_eq("R5 phase outputs", bad, 0);
        end

        // R4: long jumps, direction alternates with length
        for (int len = 2; len <= 5; len++) begin
            bit dv = len[0];
            send({3'b001, dv, 1'b0, len[2:0]});
            run_seq(dv, 1'b1, a_c, b_c, br_c, a_x, b_x, c_x, bad);
            expect_eq("R4 accel crossings", a_x, 9 << (len - 2));
            expect_eq("R4 decel crossings", b_x, 7 << (len - 2));
            expect_eq("R4 brake ticks", br_c, BRAKE);
            expect_eq("R5 phase outputs", bad, 0);
            expect_eq("R8 self clear", quiet(), 1);
        end

        // R6: track check
        send(8'h40);
        run_seq(1'b0, 1'b1, a_c, b_c, br_c, a_x, b_x, c_x, bad);
        expect_eq("R6 no kicks", a_c + b_c, 0);
        expect_eq("R6 crossings before brake", c_x, CHECK);
        expect_eq("R6 brake ticks", br_c, BRAKE);
        expect_eq("R6 outputs", bad, 0);

        // R7: brake alone, outward slip polarity
        send(8'h70);
        run_seq(1'b1, 1'b1, a_c, b_c, br_c, a_x, b_x, c_x, bad);
        expect_eq("R7 no kicks", a_c + b_c, 0);
        expect_eq("R7 brake ticks", br_c, BRAKE);
        expect_eq("R7 slip-driven trk_off", bad, 0);

        // R9: ignored bytes while idle
        send(8'h00);
        send(8'hC3);
        send(8'h28);
        send(8'h26);
        repeat (3) @(negedge clk);
        expect_eq("R9 ignored bytes leave idle", quiet(), 1);

        // R9: ignored bytes during a jump keep its timing
        send(8'h20);
        send(8'h27);
        run_seq(1'b0, 1'b0, a_c, b_c, br_c, a_x, b_x, c_x, bad);
        expect_eq("R9 accel left after ignored byte", a_c, 1);
        expect_eq("R9 decel unchanged", b_c, KICK);

        // R9: preemption of a long jump by a one-track outward jump
        send(8'h22);
        repeat (3) @(negedge clk);
        expect_eq("R9 long jump running", kick_pos, 1);
        send(8'h30);
        expect_eq("R9 new kick_neg next cycle", kick_neg, 1);
        expect_eq("R9 old kick_pos dropped", kick_pos, 0);
        run_seq(1'b1, 1'b0, a_c, b_c, br_c, a_x, b_x, c_x, bad);
        expect_eq("R9 replaced accel ticks", a_c, KICK);
        expect_eq("R9 replaced decel ticks", b_c, KICK);

        // R13: frozen tick holds a timed phase
        tick = 1'b0;
        send(8'h20);
        repeat (10) @(negedge clk);
        expect_eq("R13 kick held while tick low", kick_pos, 1);
        tick = 1'b1;
        run_seq(1'b0, 1'b0, a_c, b_c, br_c, a_x, b_x, c_x, bad);
        expect_eq("R13 accel resumes for full ticks", a_c, KICK);
        expect_eq("R13 brake after resume", br_c, BRAKE);

        // R10 R11 R12: counting
        count_run(16, 1'b0);
        count_run(17, 1'b0);
        count_run(16, 1'b1);
        expect_eq("R11 idle after stop", quiet(), 1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule